// File: doc/BRIEF.md
# Boot-Alias Address Decoder with Bus Timer

This block sits on the local bus of a 32-bit processor board and turns each transfer into one chip select: boot flash, DRAM, SRAM, local I/O, or the interrupt-vector location. It also holds a small control register. After every reset, the register maps the boot flash into the bottom 4 MB of the address space, so that the processor can fetch its reset vector from address zero. The register also keeps DRAM decoding switched off until software turns it on. Software clears the alias bit, and the low region then passes to DRAM.

A transfer opens when `xfer_start` is high for one cycle with a normal transfer type. The select is registered on that edge and held until the access ends. An access ends either when the selected device acknowledges, which is passed straight through to `xfer_ack`, or when the bus timer runs out and the block raises `xfer_err` for one clock. The bus is strobe-initiated and has no ready signal, so there is no back-pressure. A start that arrives while an access is still open is dropped, and the requester must wait for `xfer_ack` or `xfer_err` before it starts again. Control register writes use a plain write strobe.

Top module: `bootmap_decoder`

## Requirements
- R1: The flash select (`dev_cs` bit 0) is asserted for any normal-type access in 0xFF800000..0xFFBFFFFF, whatever the control register holds. 0xFF7FFFFC selects nothing.
- R2: The alias bit is control bit 20, and reset sets it to 1. While it is 1, accesses in 0x00000000..0x003FFFFF select flash, and the alias wins over DRAM. While it is 0, that range selects DRAM only if DRAM is enabled, and otherwise selects nothing.
- R3: The DRAM-enable bit (control bit 1) is 0 after reset. Until it is written to 1, no access selects DRAM (`dev_cs` bit 1), and an access to 0x00800000 selects nothing.
- R4: With DRAM enabled, accesses in 0x00000000..0x00FFFFFF select DRAM, except the low 4 MB while the alias bit is 1. 0x01000000 selects nothing.
- R5: The other selects are SRAM (`dev_cs` bit 2) for 0xFFC00000..0xFFDFFFFF, local I/O (bit 3) for 0xFFF00000..0xFFFDFFFF, and the interrupt vector (bit 4) for reads of 0xFFFE0000..0xFFFE00FF.
- R6: A start with transfer type 3 opens no access. It drives no select, no acknowledge and no error, and the next normal start is accepted.
- R7: The select appears in the cycle after the accepted start and is held, with at most one bit set, until the access ends. It is low in the cycle after the end.
- R8: `xfer_ack` follows the acknowledge of the selected device only. Acknowledges from devices that are not selected are ignored.
- R9: The timer-enable bit is control bit 0, and reset sets it to 1. With the timer enabled and no acknowledge, `xfer_err` is high for exactly one clock. It rises TIMEOUT clocks after the start edge, never coincides with `xfer_ack`, and closes the access.
- R10: With the timer disabled, an unanswered access never raises `xfer_err`.
- R11: A write to the interrupt-vector location selects nothing. A read of that location with no acknowledge, which means no interrupt is pending, ends with `xfer_err`.
- R12: A register write takes effect only when `cfg_addr` equals 0xFFF40030. A write to any other address leaves the control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Transfer-start strobe, one cycle |
| xfer_addr | input | 32 | Transfer address, valid with the start strobe |
| xfer_type | input | 2 | Transfer type; 0, 1 and 2 use the normal map |
| xfer_read | input | 1 | 1 = read, 0 = write |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 32 | Control register write address |
| cfg_wdata | input | 32 | Control register write data |
| dev_ack | input | 5 | Device acknowledges, same bit order as dev_cs |
| dev_cs | output | 5 | Chip selects: 0 flash, 1 DRAM, 2 SRAM, 3 local I/O, 4 vector |
| xfer_ack | output | 1 | Normal acknowledge from the selected device |
| xfer_err | output | 1 | Transfer-error strobe on timeout |

## Verification
A wrong alias or DRAM-enable bit shows at the ports one cycle after the next start, as the wrong select or no select for a low address. A stuck-open access shows at the next start as a missing select. A timer counter that is off by even one state moves the error strobe by a clock relative to the start edge. It can also stretch the strobe into a second cycle, or let the strobe appear after an acknowledge. Each of these cases is visible within one TIMEOUT window of the access that exposes it.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  localparam int NDEV = 5;
  localparam int D_FLASH = 0;
  localparam int D_DRAM  = 1;
  localparam int D_SRAM  = 2;
  localparam int D_LIO   = 3;
  localparam int D_IVEC  = 4;

  localparam int NWIN = 6;
  localparam int W_FLASH = 0;
  localparam int W_ALIAS = 1;
  localparam int W_DRAM  = 2;
  localparam int W_SRAM  = 3;
  localparam int W_LIO   = 4;
  localparam int W_IVEC  = 5;

  localparam int B_TMR   = 0;
  localparam int B_DRAM  = 1;
  localparam int B_ALIAS = 20;

  typedef struct packed {
    logic alias_on;
    logic dram_on;
    logic tmr_on;
  } ctrl_t;

  function automatic logic normal_type(input logic [1:0] tt);
    return tt != 2'd3;
  endfunction
endpackage

// File: rtl/bootmap_ctrl.sv
module bootmap_ctrl
  import bootmap_pkg::*;
#(
  parameter logic [31:0] CTRL_ADDR = 32'hFFF4_0030
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] waddr,
  input  logic        wbit_alias,
  input  logic        wbit_dram,
  input  logic        wbit_tmr,
  output ctrl_t       ctrl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl.alias_on <= 1'b1;
      ctrl.dram_on  <= 1'b0;
      ctrl.tmr_on   <= 1'b1;
    end else if (we && (waddr == CTRL_ADDR)) begin
      ctrl.alias_on <= wbit_alias;
      ctrl.dram_on  <= wbit_dram;
      ctrl.tmr_on   <= wbit_tmr;
    end
  end
endmodule

// File: rtl/bootmap_decode.sv
module bootmap_decode
  import bootmap_pkg::*;
#(
  parameter logic [NWIN-1:0][31:0] WIN_BASE = '0,
  parameter logic [NWIN-1:0][31:0] WIN_SIZE = '0
) (
  input  logic [31:0]     addr,
  input  logic [1:0]      ttype,
  input  logic            is_read,
  input  ctrl_t           ctrl,
  output logic [NDEV-1:0] cs
);
  logic [NWIN-1:0] hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [31:0] offs;
    assign offs   = addr - WIN_BASE[w];
    assign hit[w] = (addr >= WIN_BASE[w]) && (offs < WIN_SIZE[w]);
  end

  logic normal, low_alias;
  assign normal    = normal_type(ttype);
  assign low_alias = ctrl.alias_on & hit[W_ALIAS];

  always_comb begin
    cs = '0;
    if (normal) begin
      cs[D_FLASH] = hit[W_FLASH] | low_alias;
      cs[D_DRAM]  = ctrl.dram_on & hit[W_DRAM] & ~low_alias;
      cs[D_SRAM]  = hit[W_SRAM] & ~low_alias;
      cs[D_LIO]   = hit[W_LIO];
      cs[D_IVEC]  = is_read & hit[W_IVEC];
    end
  end
endmodule

// File: rtl/bootmap_timer.sv
module bootmap_timer #(
  parameter int TIMEOUT = 256,
  localparam int CW = $clog2(TIMEOUT + 1),
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic ack,
  input  logic enable,
  output logic busy,
  output logic err
);
  logic [CW-1:0] cnt;

  assign err = busy & enable & (cnt == LAST) & ~ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && (ack || err)) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy && open_req) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && (cnt != LAST)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
  import bootmap_pkg::*;
#(
  parameter int          TIMEOUT    = 256,
  parameter logic [31:0] CTRL_ADDR  = 32'hFFF4_0030,
  parameter logic [31:0] FLASH_BASE = 32'hFF80_0000,
  parameter logic [31:0] FLASH_SIZE = 32'h0040_0000,
  parameter logic [31:0] ALIAS_SIZE = 32'h0040_0000,
  parameter logic [31:0] DRAM_BASE  = 32'h0000_0000,
  parameter logic [31:0] DRAM_SIZE  = 32'h0100_0000,
  parameter logic [31:0] SRAM_BASE  = 32'hFFC0_0000,
  parameter logic [31:0] SRAM_SIZE  = 32'h0020_0000,
  parameter logic [31:0] LIO_BASE   = 32'hFFF0_0000,
  parameter logic [31:0] LIO_SIZE   = 32'h000E_0000,
  parameter logic [31:0] IVEC_BASE  = 32'hFFFE_0000,
  parameter logic [31:0] IVEC_SIZE  = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            xfer_start,
  input  logic [31:0]     xfer_addr,
  input  logic [1:0]      xfer_type,
  input  logic            xfer_read,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic [4:0]      dev_ack,
  output logic [4:0]      dev_cs,
  output logic            xfer_ack,
  output logic            xfer_err
);
  localparam logic [NWIN-1:0][31:0] BASES =
    {IVEC_BASE, LIO_BASE, SRAM_BASE, DRAM_BASE, 32'h0000_0000, FLASH_BASE};
  localparam logic [NWIN-1:0][31:0] SIZES =
    {IVEC_SIZE, LIO_SIZE, SIZE_OF_SRAM(), DRAM_SIZE, ALIAS_SIZE, FLASH_SIZE};

  function automatic logic [31:0] SIZE_OF_SRAM();
    return SRAM_SIZE;
  endfunction

  ctrl_t           ctrl;
  logic [NDEV-1:0] dec_cs, cs_q;
  logic            busy, open_req, err, ack;
  logic            unused_wdata;

  assign unused_wdata = ^{cfg_wdata[31:21], cfg_wdata[19:2]};

  bootmap_ctrl #(.CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
    .wbit_alias(cfg_wdata[B_ALIAS]), .wbit_dram(cfg_wdata[B_DRAM]),
    .wbit_tmr(cfg_wdata[B_TMR]), .ctrl(ctrl)
  );

  bootmap_decode #(.WIN_BASE(BASES), .WIN_SIZE(SIZES)) u_dec (
    .addr(xfer_addr), .ttype(xfer_type), .is_read(xfer_read),
    .ctrl(ctrl), .cs(dec_cs)
  );

  assign open_req = xfer_start & normal_type(xfer_type);
  assign ack      = busy & |(dev_ack & cs_q);

  bootmap_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .open_req(open_req), .ack(ack),
    .enable(ctrl.tmr_on), .busy(busy), .err(err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      cs_q <= '0;
    else if (!busy && open_req)
      cs_q <= dec_cs;
    else if (busy && (ack || err))
      cs_q <= '0;
  end

  assign dev_cs   = cs_q;
  assign xfer_ack = ack;
  assign xfer_err = err;
endmodule

// File: rtl/bootmap_chk.sv
module bootmap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_start,
  input logic [1:0] xfer_type,
  input logic [4:0] dev_cs,
  input logic       xfer_ack,
  input logic       xfer_err
);
  // R7
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_cs));

  // R7
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_start && !xfer_ack && !xfer_err) |=> $stable(dev_cs));

  // R8
  ack_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> (dev_cs != 5'd0));

  // R9
  err_not_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_ack && xfer_err));

  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !xfer_err);

  // R9
  err_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> (dev_cs == 5'd0));

  // R6
  odd_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && xfer_type == 2'd3 && dev_cs == 5'd0) |=> (dev_cs == 5'd0));
endmodule

bind bootmap_decoder bootmap_chk u_chk (.*);

// File: tb/sim_bootmap_decoder.sv
module sim_bootmap_decoder;
  localparam int TCLK = 10;
  localparam int TMO  = 256;
  localparam logic [31:0] CTRL = 32'hFFF4_0030;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 1'b0;
  logic [31:0] xfer_addr = '0;
  logic [1:0]  xfer_type = '0;
  logic        xfer_read = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [4:0]  dev_ack = '0;
  logic [4:0]  dev_cs;
  logic        xfer_ack, xfer_err;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  bootmap_decoder #(.TIMEOUT(TMO)) u0 (.*);

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] addr;
    logic [1:0]  tt;
    logic        rd;
    logic [4:0]  cs;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0010_0001, 32'hFF80_0000, 2'd0, 1'b1, 5'b00001},  // R1
    '{32'h0000_0001, 32'hFFBF_FFFC, 2'd1, 1'b1, 5'b00001},  // R1
    '{32'h0000_0001, 32'hFF7F_FFFC, 2'd0, 1'b1, 5'b00000},  // R1 edge
    '{32'h0010_0003, 32'h0020_0000, 2'd2, 1'b1, 5'b00001},  // R2 alias wins
    '{32'h0000_0001, 32'h0020_0000, 2'd0, 1'b1, 5'b00000},  // R2 no dram
    '{32'h0000_0003, 32'h0020_0000, 2'd0, 1'b0, 5'b00010},  // R4
    '{32'h0010_0003, 32'h0080_0000, 2'd0, 1'b1, 5'b00010},  // R4
    '{32'h0000_0003, 32'h00FF_FFFC, 2'd1, 1'b1, 5'b00010},  // R4
    '{32'h0000_0003, 32'h0100_0000, 2'd0, 1'b1, 5'b00000},  // R4 edge
    '{32'h0000_0001, 32'hFFC0_0000, 2'd0, 1'b0, 5'b00100},  // R5
    '{32'h0000_0001, 32'hFFF4_0030, 2'd0, 1'b1, 5'b01000},  // R5
    '{32'h0000_0001, 32'hFFFE_0004, 2'd0, 1'b1, 5'b10000},  // R5
    '{32'h0000_0001, 32'hFFFE_0004, 2'd0, 1'b0, 5'b00000}   // R11 write
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start(input logic [31:0] a, input logic [1:0] tt, input logic rd);
    @(negedge clk);
    xfer_start = 1'b1; xfer_addr = a; xfer_type = tt; xfer_read = rd;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic finish_ack(input string req, input logic [4:0] cs);
    dev_ack = cs;
    #1;
    check(req, "ack", {31'd0, xfer_ack}, 32'd1);
    check(req, "err with ack", {31'd0, xfer_err}, 32'd0);
    @(negedge clk);
    dev_ack = '0;
    check(req, "cs after ack", {27'd0, dev_cs}, 32'd0);
  endtask

  task automatic wait_err(input string req);
    int n = 1;
    while (!xfer_err && n < 2 * TMO) begin
      @(negedge clk);
      n++;
    end
    check(req, "err delay", n, TMO);
    @(negedge clk);
    check(req, "err width", {31'd0, xfer_err}, 32'd0);
    check(req, "cs after err", {27'd0, dev_cs}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int errs;
    do_reset();
    // R7: reset state
    check("R7", "reset cs", {27'd0, dev_cs}, 32'd0);
    check("R9", "reset err", {31'd0, xfer_err}, 32'd0);
    check("R8", "reset ack", {31'd0, xfer_ack}, 32'd0);

    // R12: write elsewhere ignored, alias still on
    cfg_write(32'hFFF4_0034, 32'h0000_0003);
    start(32'h0000_0000, 2'd0, 1'b1);
    check("R2", "reset alias", {27'd0, dev_cs}, 32'h01);
    check("R12", "foreign write", {27'd0, dev_cs}, 32'h01);
    finish_ack("R2", 5'b00001);

    // R3: dram off after reset
    start(32'h0080_0000, 2'd0, 1'b1);
    check("R3", "dram off", {27'd0, dev_cs}, 32'd0);
    wait_err("R3");

    // R8: acks from unselected devices ignored
    start(32'hFF80_0000, 2'd0, 1'b1);
    dev_ack = 5'b11110;
    #1;
    check("R8", "foreign ack", {31'd0, xfer_ack}, 32'd0);
    @(negedge clk);
    check("R7", "cs held", {27'd0, dev_cs}, 32'h01);
    finish_ack("R8", 5'b00001);

    // R6: type 3 opens nothing
    start(32'hFF80_0000, 2'd3, 1'b1);
    check("R6", "type3 cs", {27'd0, dev_cs}, 32'd0);
    errs = 0;
    for (int i = 0; i < TMO + 4; i++) begin
      @(negedge clk);
      if (xfer_err || xfer_ack) errs++;
    end
    check("R6", "type3 response", errs, 0);
    start(32'hFF80_0000, 2'd0, 1'b1);
    check("R6", "next start", {27'd0, dev_cs}, 32'h01);
    finish_ack("R6", 5'b00001);

    // R11: vector read with no interrupt pending
    start(32'hFFFE_0000, 2'd0, 1'b1);
    check("R11", "vector cs", {27'd0, dev_cs}, 32'h10);
    wait_err("R11");

    // table walk
    for (int v = 0; v < NV; v++) begin
      cfg_write(CTRL, VECS[v].ctrl);
      start(VECS[v].addr, VECS[v].tt, VECS[v].rd);
      check($sformatf("R5 vec%0d", v), "cs", {27'd0, dev_cs}, {27'd0, VECS[v].cs});
      if (VECS[v].cs != 5'd0) finish_ack("R8", VECS[v].cs);
      else wait_err("R9");
    end

    // R10: timer disabled, no error
    cfg_write(CTRL, 32'h0000_0000);
    start(32'hFFE0_0000, 2'd0, 1'b1);
    errs = 0;
    for (int i = 0; i < TMO + 8; i++) begin
      @(negedge clk);
      if (xfer_err) errs++;
    end
    check("R10", "err with timer off", errs, 0);
    do_reset();
    check("R7", "cs after reset", {27'd0, dev_cs}, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule